// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Readout Sequencer

This block drives a multi-channel ADC with a parallel data bus from a synchronous system clock. A one-cycle start request in idle makes it pulse the active-low conversion-start pin. It then waits for the converter's busy line to rise and, later, to fall. Busy covers the end-of-conversion pulses of every selected channel. Once busy falls, the block reads one word per selected channel. Each read lowers chip-select and the read strobe together, and the word is captured at the last cycle of the strobe's low phase. Each captured word leaves the block as a single-cycle stream beat. The beat carries the 12-bit data, the channel number and an ordering flag. The ordering flag comes from the converter's first-data pin.

A separate configuration request performs one write cycle on the bus. The write loads the channel-select mask into the converter, and the block keeps its own copy. That copy sets how many words are read and which channel number each word gets. Every pulse width, gap and timeout is a whole number of clock cycles set by parameters. The busy timeout grows with the number of selected channels. A busy line that never rises, or never falls, sets a sticky error and returns the block to idle. Requests that cannot be served are dropped and counted.

The controller has eight states:
- IDLE
- WR_LOW (write strobe low)
- WR_HOLD (data held after the write strobe rises)
- CONV (start pulse low)
- BUSY_RISE (waiting for busy)
- BUSY_WAIT (waiting for busy to end)
- RD_LOW (read strobe low)
- RD_GAP (read strobe high between reads)

Its transitions are:
- IDLE→WR_LOW: configuration request.
- IDLE→CONV: start request with a non-empty mask.
- WR_LOW→WR_HOLD, WR_HOLD→IDLE, CONV→BUSY_RISE: phase count expired.
- BUSY_RISE→BUSY_WAIT: busy seen high.
- BUSY_RISE→IDLE, BUSY_WAIT→IDLE: timeout.
- BUSY_WAIT→RD_LOW: busy seen low.
- RD_LOW→RD_GAP: capture.
- RD_GAP→RD_LOW: channels remain.
- RD_GAP→IDLE: last channel read.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the start, chip-select, read and write pins are high and the bus drive enable is low. There is no stream beat, the timeout flag and the drop count are zero, and the channel mask holds all ones (every channel selected).
- R2: A start request accepted in idle drives the start pin low for exactly T_CONVST cycles (default 4).
- R3: After busy falls, the block reads one word for each set bit of the mask, in ascending channel order. Each read holds the read strobe low for exactly T_RD_LOW cycles (default 4). The word on the bus at the last low cycle appears on out_data with out_valid high for one cycle, and out_chan carries the bit position of that channel.
- R4: Between two reads of one sequence, the read strobe stays high for at least T_RD_GAP cycles (default 3).
- R5: out_order_err is high on the first word of a sequence when the first-data pin is low at its capture, and it is low on every other word.
- R6: If busy is not seen high within T_BUSY_RISE cycles after the start pulse, the block returns to idle with no reads and timeout_err rises. The same happens if busy stays high longer than N·(T_CONV+T_EOC)−T_EOC+T_MARGIN cycles, where N is the number of selected channels. timeout_err then stays high until reset.
- R7: A configuration request in idle performs one write. Chip-select and the write strobe go low, and the write strobe stays low for T_WR_LOW cycles (default 2). The drive enable is high during the low phase and for T_WR_HOLD further cycles, with cfg_mask zero-extended on adc_db_out. The mask is stored for later sequences.
- R8: Some requests are ignored. This covers a start or configuration request outside idle, a start with an empty mask, and a start in the same cycle as a configuration request (the configuration wins). An ignored request changes neither the mask nor the pins. Each cycle with at least one ignored request adds one to drop_count, which saturates.
- R9: Chip-select is low whenever the read or write strobe is low, and at most one of the start, read and write strobes is low at a time.
- R10: The drive enable is never high while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request for a conversion sequence |
| cfg_req | input | 1 | One-cycle request to write the channel mask |
| cfg_mask | input | NCH | Channel mask written by cfg_req |
| adc_convst_n | output | 1 | Active-low conversion-start pulse |
| adc_busy | input | 1 | Converter busy, asynchronous |
| adc_cs_n | output | 1 | Active-low chip-select |
| adc_rd_n | output | 1 | Active-low read strobe |
| adc_wr_n | output | 1 | Active-low write strobe |
| adc_db_in | input | DATA_W | Data bus from the converter |
| adc_db_out | output | DATA_W | Data bus towards the converter |
| adc_db_oe | output | 1 | Drive enable for adc_db_out |
| adc_frst | input | 1 | First-data flag from the converter |
| out_valid | output | 1 | Stream beat valid |
| out_data | output | DATA_W | Captured conversion word |
| out_chan | output | CH_W | Channel number of the word |
| out_order_err | output | 1 | First word arrived without the first-data flag |
| timeout_err | output | 1 | Sticky busy timeout |
| drop_count | output | DROP_W | Saturating count of cycles with ignored requests |

## Verification
The main function is tried with five masks:
- All four channels after reset, which tests the default mask.
- Two separated channels, which tells ascending-order tagging apart from plain ordinal numbering.
- A lone top channel, which tests a one-word sequence and the shortest busy window.
- A pair of inner channels with the first-data flag held low, which separates a first-word order error from a flag that marks every word.
- Two low channels, used while extra requests arrive during the conversion.

Each converted word encodes both the channel and a per-sequence tag, so a stale, swapped or duplicated capture shows up as a data mismatch. A busy line that never rises and one that never falls exercise the two timeout paths. A check between the two points of the long window shows that the timeout tracks the channel count rather than firing early.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_LOW,
        S_WR_HOLD,
        S_CONV,
        S_BUSY_RISE,
        S_BUSY_WAIT,
        S_RD_LOW,
        S_RD_GAP
    } seq_state_e;

endpackage

// File: rtl/adc_seq_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for an asynchronous level input.
module adc_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
// Shared phase counter: load a value, count down to zero and hold there.
module adc_seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (load)     cnt <= val;
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/adc_seq_chan_pick.sv
`timescale 1ns/1ps
// Lowest set channel of a mask, plus the number of set channels.
module adc_seq_chan_pick #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  mask,
    output logic [CH_W-1:0] idx,
    output logic            any,
    output logic [CH_W:0]   count
);
    always_comb begin
        idx   = '0;
        count = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) idx = CH_W'(i);
            count = count + (CH_W + 1)'(mask[i]);
        end
        any = |mask;
    end
endmodule

// File: rtl/adc_seq_sat_cnt.sv
`timescale 1ns/1ps
// Saturating event counter.
module adc_seq_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (inc && cnt != '1) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int NCH         = 4,
    parameter int TMR_W       = 16,
    parameter int DROP_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int T_CONVST    = 4,    // start low, cycles (>= 35 ns)
    parameter int T_BUSY_RISE = 12,   // busy must appear within this
    parameter int T_CONV      = 165,  // per-channel conversion, cycles
    parameter int T_EOC       = 18,   // end-of-conversion pulse max, cycles
    parameter int T_MARGIN    = 32,   // slack on the busy window
    parameter int T_RD_LOW    = 4,    // read strobe low (>= 35 ns access)
    parameter int T_RD_GAP    = 3,    // gap and bus release between reads
    parameter int T_WR_LOW    = 2,    // write strobe low (>= 20 ns)
    parameter int T_WR_HOLD   = 1,    // data hold after write rises
    localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              cfg_req,
    input  logic [NCH-1:0]    cfg_mask,
    output logic              adc_convst_n,
    input  logic              adc_busy,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic              adc_wr_n,
    input  logic [DATA_W-1:0] adc_db_in,
    output logic [DATA_W-1:0] adc_db_out,
    output logic              adc_db_oe,
    input  logic              adc_frst,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CH_W-1:0]   out_chan,
    output logic              out_order_err,
    output logic              timeout_err,
    output logic [DROP_W-1:0] drop_count
);
    localparam int SLOT = T_CONV + T_EOC;

    seq_state_e state_q, state_d;

    logic             busy_s;
    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic [NCH-1:0]   mask_q, rem_q, pick_in;
    logic [CH_W-1:0]  pick_idx;
    logic             pick_any;
    logic [CH_W:0]    pick_cnt;
    logic             first_q;
    logic             take_start, take_cfg, capture, to_err;
    logic [TMR_W-1:0] busy_lim;

    adc_seq_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk(clk), .rst_n(rst_n), .d(adc_busy), .q(busy_s)
    );

    adc_seq_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
    );

    assign pick_in = (state_q == S_IDLE) ? mask_q : rem_q;

    adc_seq_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .mask(pick_in), .idx(pick_idx), .any(pick_any), .count(pick_cnt)
    );

    adc_seq_sat_cnt #(.W(DROP_W)) u_drop (
        .clk(clk), .rst_n(rst_n),
        .inc((start_req && !take_start) || (cfg_req && !take_cfg)),
        .cnt(drop_count)
    );

    // Busy window for the selected channels, minus one for the load cycle.
    assign busy_lim = TMR_W'(pick_cnt) * TMR_W'(SLOT) - TMR_W'(T_EOC)
                    + TMR_W'(T_MARGIN) - TMR_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and phase timer loads
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        take_start = 1'b0;
        take_cfg   = 1'b0;
        capture    = 1'b0;
        to_err     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cfg_req) begin
                    state_d  = S_WR_LOW;
                    take_cfg = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_WR_LOW - 1);
                end else if (start_req && pick_any) begin
                    state_d    = S_CONV;
                    take_start = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = TMR_W'(T_CONVST - 1);
                end
            end
            S_WR_LOW: begin
                if (tmr_zero) begin
                    state_d  = S_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_WR_HOLD - 1);
                end
            end
            S_WR_HOLD: begin
                if (tmr_zero) state_d = S_IDLE;
            end
            S_CONV: begin
                if (tmr_zero) begin
                    state_d  = S_BUSY_RISE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_BUSY_RISE - 1);
                end
            end
            S_BUSY_RISE: begin
                if (busy_s) begin
                    state_d  = S_BUSY_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = busy_lim;
                end else if (tmr_zero) begin
                    state_d = S_IDLE;
                    to_err  = 1'b1;
                end
            end
            S_BUSY_WAIT: begin
                if (!busy_s) begin
                    state_d  = S_RD_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_RD_LOW - 1);
                end else if (tmr_zero) begin
                    state_d = S_IDLE;
                    to_err  = 1'b1;
                end
            end
            S_RD_LOW: begin
                if (tmr_zero) begin
                    state_d  = S_RD_GAP;
                    capture  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_RD_GAP - 1);
                end
            end
            S_RD_GAP: begin
                if (tmr_zero) begin
                    if (rem_q == '0) begin
                        state_d = S_IDLE;
                    end else begin
                        state_d  = S_RD_LOW;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(T_RD_LOW - 1);
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Registered outputs, aligned with the state they belong to
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_convst_n  <= 1'b1;
            adc_cs_n      <= 1'b1;
            adc_rd_n      <= 1'b1;
            adc_wr_n      <= 1'b1;
            adc_db_oe     <= 1'b0;
            adc_db_out    <= '0;
            out_valid     <= 1'b0;
            out_data      <= '0;
            out_chan      <= '0;
            out_order_err <= 1'b0;
            timeout_err   <= 1'b0;
        end else begin
            adc_convst_n <= (state_d != S_CONV);
            adc_rd_n     <= (state_d != S_RD_LOW);
            adc_wr_n     <= (state_d != S_WR_LOW);
            adc_cs_n     <= !(state_d inside {S_WR_LOW, S_WR_HOLD, S_RD_LOW});
            adc_db_oe    <= (state_d inside {S_WR_LOW, S_WR_HOLD});
            if (take_cfg) adc_db_out <= DATA_W'(cfg_mask);
            out_valid <= capture;
            if (capture) begin
                out_data      <= adc_db_in;
                out_chan      <= pick_idx;
                out_order_err <= first_q && !adc_frst;
            end
            if (to_err) timeout_err <= 1'b1;
        end
    end

    // Channel bookkeeping for one sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            rem_q   <= '0;
            first_q <= 1'b0;
        end else begin
            if (take_cfg) mask_q <= cfg_mask;
            if (take_start) begin
                rem_q   <= mask_q;
                first_q <= 1'b1;
            end else if (capture) begin
                rem_q[pick_idx] <= 1'b0;
                first_q         <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk #(
    parameter int DROP_W   = 8,
    parameter int T_CONVST = 4,
    parameter int T_RD_LOW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_convst_n,
    input logic              adc_cs_n,
    input logic              adc_rd_n,
    input logic              adc_wr_n,
    input logic              adc_db_oe,
    input logic              out_valid,
    input logic              timeout_err,
    input logic [DROP_W-1:0] drop_count
);
    logic [7:0] cv_lo, rd_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cv_lo <= '0;
            rd_lo <= '0;
        end else begin
            cv_lo <= adc_convst_n ? 8'd0 : cv_lo + 8'd1;
            rd_lo <= adc_rd_n     ? 8'd0 : rd_lo + 8'd1;
        end
    end

    AST_CONVST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_convst_n) |-> (cv_lo == 8'(T_CONVST))); // R2
    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rd_n) |-> (rd_lo == 8'(T_RD_LOW))); // R3
    AST_BEAT_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $rose(adc_rd_n)); // R3
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err); // R6
    AST_DROP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count >= $past(drop_count)); // R8
    AST_CS_COVERS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_rd_n || !adc_wr_n) |-> !adc_cs_n); // R9
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!adc_rd_n, !adc_wr_n, !adc_convst_n})); // R9
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> !adc_db_oe); // R10
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .DROP_W(DROP_W), .T_CONVST(T_CONVST), .T_RD_LOW(T_RD_LOW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n),
    .adc_rd_n(adc_rd_n), .adc_wr_n(adc_wr_n), .adc_db_oe(adc_db_oe),
    .out_valid(out_valid), .timeout_err(timeout_err), .drop_count(drop_count)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
    localparam int DATA_W = 12;
    localparam int NCH    = 4;
    localparam int CH_W   = 2;
    localparam int SEQ_WAIT = 900;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              start_req = 1'b0, cfg_req = 1'b0;
    logic [NCH-1:0]    cfg_mask = '0;
    logic              adc_convst_n, adc_cs_n, adc_rd_n, adc_wr_n, adc_db_oe;
    logic              busy_m = 1'b0, frst_m = 1'b0;
    logic [DATA_W-1:0] db_m = '0, adc_db_out, out_data;
    logic              out_valid, out_order_err, timeout_err;
    logic [CH_W-1:0]   out_chan;
    logic [7:0]        drop_count;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_req(cfg_req),
        .cfg_mask(cfg_mask), .adc_convst_n(adc_convst_n), .adc_busy(busy_m),
        .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_wr_n(adc_wr_n),
        .adc_db_in(db_m), .adc_db_out(adc_db_out), .adc_db_oe(adc_db_oe),
        .adc_frst(frst_m), .out_valid(out_valid), .out_data(out_data),
        .out_chan(out_chan), .out_order_err(out_order_err),
        .timeout_err(timeout_err), .drop_count(drop_count)
    );

    int checks = 0, failures = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [NCH-1:0] dev_mask = '1;
    int  seq_tag = 0, rd_idx = 0;
    bit  stuck = 0, dead = 0, bad_frst = 0;

    function automatic int popc(input logic [NCH-1:0] m);
        int n = 0;
        for (int i = 0; i < NCH; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic int kth(input logic [NCH-1:0] m, input int k);
        int seen = 0;
        for (int i = 0; i < NCH; i++)
            if (m[i]) begin
                if (seen == k) return i;
                seen++;
            end
        return 0;
    endfunction

    function automatic logic [DATA_W-1:0] mk_word(input int ch, input int tag);
        return DATA_W'(ch * 512 + tag * 7 + 1);
    endfunction

    initial forever begin
        @(posedge adc_convst_n);
        if (rst_n) begin
            rd_idx = 0;
            if (!dead) begin
                #30 busy_m = 1'b1;
                if (!stuck) begin
                    #(popc(dev_mask) * 1780 - 180);
                    busy_m = 1'b0;
                end
            end
        end
    end

    initial forever begin
        @(negedge adc_rd_n);
        #15;
        if (!adc_cs_n) begin
            db_m   = mk_word(kth(dev_mask, rd_idx), seq_tag);
            frst_m = !bad_frst && (rd_idx == 0);
        end
        @(posedge adc_rd_n);
        rd_idx++;
        #10;
        db_m   = '0;
        frst_m = 1'b0;
    end

    initial forever begin
        @(posedge adc_wr_n);
        if (!adc_cs_n && adc_db_oe) dev_mask = adc_db_out[NCH-1:0];
    end

    // ---------------- scoreboard monitor ----------------
    logic [DATA_W+CH_W:0] exp_q[$];
    int cv_lo = 0, rd_lo = 0, rd_hi = 0, wr_lo = 0, conv_pulses = 0;
    bit gap_open = 0, cs_bad = 0, oe_bad = 0, wr_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!adc_convst_n) cv_lo++;
            else if (cv_lo != 0) begin
                chk("R2 start pulse width", cv_lo, 4);
                cv_lo = 0;
                conv_pulses++;
            end

            if (!adc_rd_n) begin
                if (gap_open) begin
                    chk("R4 gap between reads", int'(rd_hi >= 3), 1);
                    gap_open = 0;
                end
                rd_lo++;
                if (adc_cs_n) cs_bad = 1;
                if (adc_db_oe) oe_bad = 1;
            end else begin
                if (rd_lo != 0) begin
                    chk("R3 read strobe width", rd_lo, 4);
                    chk("R9 cs low during read", int'(cs_bad), 0);
                    chk("R10 no drive during read", int'(oe_bad), 0);
                    rd_lo = 0; cs_bad = 0; oe_bad = 0;
                    gap_open = 1; rd_hi = 0;
                end
                rd_hi++;
                if (rd_hi > 20) gap_open = 0;
            end

            if (!adc_wr_n) begin
                wr_lo++;
                if (adc_cs_n || !adc_db_oe) wr_bad = 1;
            end else if (wr_lo != 0) begin
                chk("R7 write strobe width", wr_lo, 2);
                chk("R7 cs and drive during write", int'(wr_bad), 0);
                chk("R7 drive held after write", int'(adc_db_oe && !adc_cs_n), 1);
                wr_lo = 0; wr_bad = 0;
            end

            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected word", int'(out_data), -1);
                end else begin
                    logic [DATA_W+CH_W:0] e;
                    e = exp_q.pop_front();
                    chk("R3 word data", int'(out_data), int'(e[DATA_W-1:0]));
                    chk("R3 channel tag", int'(out_chan), int'(e[DATA_W+CH_W-1:DATA_W]));
                    chk("R5 order flag", int'(out_order_err), int'(e[DATA_W+CH_W]));
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic pulse_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic write_cfg(input logic [NCH-1:0] m);
        @(negedge clk) begin cfg_req = 1'b1; cfg_mask = m; end
        @(negedge clk) cfg_req = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 mask written to converter", int'(dev_mask), int'(m));
    endtask

    task automatic push_exp(input logic [NCH-1:0] m, input bit bad, input int tag);
        bit first = 1;
        for (int ch = 0; ch < NCH; ch++)
            if (m[ch]) begin
                exp_q.push_back({bad && first, CH_W'(ch), mk_word(ch, tag)});
                first = 0;
            end
    endtask

    task automatic run_seq(input logic [NCH-1:0] m, input bit bad, input int tag);
        seq_tag  = tag;
        bad_frst = bad;
        push_exp(m, bad, tag);
        pulse_start();
        repeat (SEQ_WAIT) @(negedge clk);
        chk("R3 all words delivered", exp_q.size(), 0);
        bad_frst = 0;
    endtask

    task automatic check_reset_state();
        chk("R1 start pin", int'(adc_convst_n), 1);
        chk("R1 cs pin", int'(adc_cs_n), 1);
        chk("R1 read pin", int'(adc_rd_n), 1);
        chk("R1 write pin", int'(adc_wr_n), 1);
        chk("R1 drive enable", int'(adc_db_oe), 0);
        chk("R1 no beat", int'(out_valid), 0);
        chk("R1 timeout flag", int'(timeout_err), 0);
        chk("R1 drop count", int'(drop_count), 0);
    endtask

    bit done = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_seq(4'hF, 0, 1);          // R1 default mask: all channels
        write_cfg(4'b0101);
        run_seq(4'b0101, 0, 2);       // R3 sparse mask, ascending tags
        write_cfg(4'b1000);
        run_seq(4'b1000, 0, 3);       // R3 single top channel
        write_cfg(4'b0110);
        run_seq(4'b0110, 1, 4);       // R5 first-data flag missing

        // R8: start and configuration during a conversion are dropped
        write_cfg(4'b0011);
        seq_tag = 5;
        push_exp(4'b0011, 0, 5);
        pulse_start();
        repeat (50) @(negedge clk);
        pulse_start();
        @(negedge clk) begin cfg_req = 1'b1; cfg_mask = 4'b1100; end
        @(negedge clk) cfg_req = 1'b0;
        repeat (SEQ_WAIT) @(negedge clk);
        chk("R8 no extra words", exp_q.size(), 0);
        chk("R8 drops counted", int'(drop_count), 2);
        chk("R8 mask untouched on converter", int'(dev_mask), 3);
        run_seq(4'b0011, 0, 6);       // R8 stored mask unchanged

        // R8: simultaneous requests, configuration wins
        c0 = conv_pulses;
        @(negedge clk) begin cfg_req = 1'b1; start_req = 1'b1; cfg_mask = 4'b1001; end
        @(negedge clk) begin cfg_req = 1'b0; start_req = 1'b0; end
        repeat (20) @(negedge clk);
        chk("R8 start dropped with cfg", int'(drop_count), 3);
        chk("R8 no conversion with cfg", conv_pulses, c0);
        chk("R7 cfg taken over start", int'(dev_mask), 9);
        run_seq(4'b1001, 0, 7);

        // R8: empty mask
        write_cfg(4'b0000);
        c0 = conv_pulses;
        pulse_start();
        repeat (20) @(negedge clk);
        chk("R8 empty mask start dropped", int'(drop_count), 4);
        chk("R8 empty mask no conversion", conv_pulses, c0);

        // R6: busy never rises
        write_cfg(4'hF);
        dead = 1;
        pulse_start();
        repeat (60) @(negedge clk);
        chk("R6 timeout on missing busy", int'(timeout_err), 1);
        dead = 0;
        run_seq(4'hF, 0, 8);          // R6 back in idle afterwards

        // R1 again after a second reset
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6: busy never falls, timeout scales with channel count
        stuck = 1;
        pulse_start();
        repeat (400) @(negedge clk);
        chk("R6 no early timeout", int'(timeout_err), 0);
        repeat (500) @(negedge clk);
        chk("R6 timeout on stuck busy", int'(timeout_err), 1);
        chk("R6 no words after timeout", exp_q.size(), 0);
        stuck = 0;
        busy_m = 1'b0;
        repeat (10) @(negedge clk);
        run_seq(4'hF, 0, 9);
        chk("R6 timeout flag sticky", int'(timeout_err), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule